// File: doc/BRIEF.md
# Adaptive Parity-to-SECDED Row Protection Controller

This controller guards a small array of memory rows whose cells wear out and become permanently stuck. Rows begin with nothing but a single parity bit. The first time a read finds that parity no longer matches, the controller pins down the stuck cell. It does this by writing the inverted word into the row and reading it back. It then restores the correct word and assigns the row a check-bit entry from a small associative pool. From then on, that row is read through a single-error-correcting, double-error-detecting extended Hamming code. The extended code's overall-parity term reuses the row's own parity bit. If a protected row later shows two bad bits, the controller runs the same locate-and-restore sequence, returns the corrected word, and pulses a scramble request naming the block of rows that holds the failing row.

The entry pool is split evenly across blocks. The `pool_global` input selects the policy. When it is low, a row may draw only from its own block's share. When it is high, a row may take any free entry. If a row needs an entry and its permitted pool is empty, the row is marked unrepairable: its raw word is returned with an error flag, and a sticky per-row flag is set. The row array is a behavioural model with a fault-injection port. Reset clears both its contents and any injected faults.

The controller is built around five states:
- `ST_IDLE` accepts requests. A write completes in this state.
- `ST_EVAL` decodes a read.
- `ST_INVERT` writes the complemented word.
- `ST_COMPARE` reads it back and forms the stuck mask.
- `ST_RESTORE` writes the repaired word, allocates the entry when one is needed, and responds.

The transitions are:
- IDLE→EVAL on an accepted read.
- EVAL→IDLE when the read is clean, is single-corrected, or finds the pool exhausted.
- EVAL→INVERT on a first fault with room in the pool, or on a double fault.
- INVERT→COMPARE, then COMPARE→RESTORE, then RESTORE→IDLE, each unconditionally.

Top module: `prot_adapt_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `scr_req` are 0, `unrep` is all zeros, and no row owns a check-bit entry.
- R2: A read of a fault-free row returns the last word written to it with `rsp_err` = 0. A write takes one cycle and leaves `req_ready` high.
- R3: A read of a row with no entry whose parity mismatches, while its permitted pool has a free entry, runs the complement-write/read-back locate. It returns the word with the stuck bit (one whose stuck value opposes the written value) flipped back, `rsp_err` = 0, and allocates an entry to the row.
- R4: A read of a row holding an entry, with one bad data bit, is corrected from the Hamming syndrome without the locate sequence and without a scramble request.
- R5: A read of a row holding an entry, with two bad data bits, returns the corrected word with `rsp_err` = 0. It raises `scr_req` for exactly one cycle, in the same cycle as `rsp_valid`, with `scr_blk` = row index divided by BLK_ROWS (rows 0–3 give 0, rows 4–7 give 1).
- R6: With `pool_global` = 0, block b may use only entries b·(NENT/NBLK) to b·(NENT/NBLK)+NENT/NBLK−1. With `pool_global` = 1, any row may take any free entry.
- R7: When a first fault finds no free entry in the permitted pool, the raw stuck word is returned with `rsp_err` = 1 and `unrep[row]` is set. That bit stays set until reset, and `rsp_err` is only ever 1 when some `unrep` bit is set.
- R8: `req_ready` is low while any state other than IDLE is active. A request presented then is held and later served. Every accepted read yields exactly one response, and a response appears only while `req_ready` is high.
- R9: A pulse on `flt_en` makes cell (`flt_row`, `flt_bit`) read as `flt_val` from then on, whatever is written to it.
- R10: A write to a row that holds an entry refreshes the entry's check bits, so later single faults in that row are still corrected against the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pool_global | input | 1 | 0: block-local entry pools, 1: one shared pool |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_row | input | $clog2(NROWS) | Row index |
| req_wdata | input | DW | Write word |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DW | Read word |
| rsp_err | output | 1 | Word could not be repaired |
| scr_req | output | 1 | One-cycle scramble request |
| scr_blk | output | $clog2(NROWS/BLK_ROWS) | Block to scramble |
| unrep | output | NROWS | Sticky per-row unrepairable flags |
| flt_en | input | 1 | Inject a stuck cell |
| flt_row | input | $clog2(NROWS) | Row of the injected cell |
| flt_bit | input | $clog2(DW) | Bit of the injected cell |
| flt_val | input | 1 | Stuck value |

## Verification
The bench drives the row lifecycle end to end: clean rows, a first fault, a single fault in a protected row, a rewrite of a protected row, and a second fault. Each step is scored against a shadow copy of the written words.

It issues reads back to back so that requests land while the locate sequence is busy. A controller that dropped a stalled request would leave expected entries in the scoreboard. One that failed to refresh check bits on a write would miscorrect the rewritten row.

The pool is pushed to exhaustion in both modes. In local mode, a third faulty row in one block must be refused even though the other block's entries are free; a design that ignored the block boundary would repair it. In global mode, a fourth faulty row in one block must still be repaired. The refused rows must come back raw with the error flag and a sticky `unrep` bit, and the double-fault case must produce exactly one scramble pulse naming block 0.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_INVERT,
        ST_COMPARE,
        ST_RESTORE
    } prot_state_e;

    // Number of Hamming check bits needed for dw data bits.
    function automatic int hamming_bits(int dw);
        int p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Codeword position (1-based, powers of two skipped) of data bit idx.
    function automatic int data_pos(int idx);
        int pos = 2;
        int cnt = -1;
        while (cnt < idx) begin
            pos++;
            if ((pos & (pos - 1)) != 0) cnt++;
        end
        return pos;
    endfunction

    // Data bits covered by check bit b.
    function automatic logic [63:0] cover_mask(int dw, int b);
        logic [63:0] m = '0;
        for (int i = 0; i < dw; i++)
            if (((data_pos(i) >> b) & 1) == 1) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/prot_hamming_enc.sv
module prot_hamming_enc
    import prot_pkg::*;
#(
    parameter int DW = 8,
    parameter int P  = 4
) (
    input  logic [DW-1:0] d,
    output logic [P-1:0]  chk,
    output logic          dpar
);

    for (genvar b = 0; b < P; b++) begin : g_chk
        localparam logic [63:0] MASK = cover_mask(DW, b);
        assign chk[b] = ^(d & MASK[DW-1:0]);
    end

    assign dpar = ^d;

endmodule

// File: rtl/prot_row_array.sv
module prot_row_array #(
    parameter int DW    = 8,
    parameter int NROWS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NROWS)-1:0] addr,
    input  logic                     we,
    input  logic [DW-1:0]            wdata,
    input  logic                     wpar,
    output logic [DW-1:0]            rdata,
    output logic                     rpar,
    input  logic                     flt_en,
    input  logic [$clog2(NROWS)-1:0] flt_row,
    input  logic [$clog2(DW)-1:0]    flt_bit,
    input  logic                     flt_val
);

    logic [DW-1:0] cell_q  [NROWS];
    logic [DW-1:0] smask_q [NROWS];
    logic [DW-1:0] sval_q  [NROWS];
    logic [NROWS-1:0] par_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= '0;
            for (int r = 0; r < NROWS; r++) begin
                cell_q[r]  <= '0;
                smask_q[r] <= '0;
                sval_q[r]  <= '0;
            end
        end else begin
            if (we) begin
                cell_q[addr] <= wdata;
                par_q[addr]  <= wpar;
            end
            if (flt_en) begin
                smask_q[flt_row][flt_bit] <= 1'b1;
                sval_q[flt_row][flt_bit]  <= flt_val;
            end
        end
    end

    assign rdata = (cell_q[addr] & ~smask_q[addr]) | (sval_q[addr] & smask_q[addr]);
    assign rpar  = par_q[addr];

endmodule

// File: rtl/prot_entry_table.sv
module prot_entry_table #(
    parameter int NROWS = 8,
    parameter int NENT  = 4,
    parameter int NBLK  = 2,
    parameter int P     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glob,
    input  logic [$clog2(NROWS)-1:0] lk_row,
    output logic                     hit,
    output logic [$clog2(NENT)-1:0]  hit_idx,
    output logic [P-1:0]             hit_chk,
    output logic                     free_ok,
    output logic [$clog2(NENT)-1:0]  free_idx,
    input  logic                     wr_en,
    input  logic [$clog2(NENT)-1:0]  wr_idx,
    input  logic [$clog2(NROWS)-1:0] wr_row,
    input  logic [P-1:0]             wr_chk
);

    localparam int ROW_W = $clog2(NROWS);
    localparam int IDX_W = $clog2(NENT);
    localparam int BLK_W = $clog2(NBLK);
    localparam int EPB   = NENT / NBLK;

    logic [NENT-1:0]  vld_q;
    logic [ROW_W-1:0] row_t [NENT];
    logic [P-1:0]     chk_t [NENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int e = 0; e < NENT; e++) begin
                row_t[e] <= '0;
                chk_t[e] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            row_t[wr_idx] <= wr_row;
            chk_t[wr_idx] <= wr_chk;
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_chk = '0;
        for (int e = 0; e < NENT; e++) begin
            if (vld_q[e] && row_t[e] == lk_row) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(e);
                hit_chk = chk_t[e];
            end
        end
    end

    // Lowest free entry in the permitted pool.
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int e = NENT - 1; e >= 0; e--) begin
            if (!vld_q[e] && (glob || BLK_W'(e / EPB) == lk_row[ROW_W-1 -: BLK_W])) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/prot_adapt_ctrl.sv
module prot_adapt_ctrl
    import prot_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NROWS    = 8,
    parameter int BLK_ROWS = 4,
    parameter int NENT     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pool_global,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [$clog2(NROWS)-1:0]          req_row,
    input  logic [DW-1:0]                     req_wdata,
    output logic                              req_ready,
    output logic                              rsp_valid,
    output logic [DW-1:0]                     rsp_data,
    output logic                              rsp_err,
    output logic                              scr_req,
    output logic [$clog2(NROWS/BLK_ROWS)-1:0] scr_blk,
    output logic [NROWS-1:0]                  unrep,
    input  logic                              flt_en,
    input  logic [$clog2(NROWS)-1:0]          flt_row,
    input  logic [$clog2(DW)-1:0]             flt_bit,
    input  logic                              flt_val
);

    localparam int ROW_W = $clog2(NROWS);
    localparam int NBLK  = NROWS / BLK_ROWS;
    localparam int BLK_W = $clog2(NBLK);
    localparam int IDX_W = $clog2(NENT);
    localparam int P     = hamming_bits(DW);

    prot_state_e state_q, state_d;

    logic [ROW_W-1:0] row_q, arr_addr;
    logic [DW-1:0]    raw_q, stuck_q, fixed_w, enc_in, flip;
    logic [DW-1:0]    arr_rdata, arr_wdata;
    logic             arr_rpar, arr_we, dpar, dbl_q;
    logic [P-1:0]     enc_chk, hit_chk, syn;
    logic [IDX_W-1:0] hit_idx, free_idx, tbl_idx;
    logic             hit, free_ok, tbl_we;
    logic             rd_acc, wr_acc, par_err, sec_single, sec_double, no_room, need_loc;

    assign req_ready = (state_q == ST_IDLE);
    assign rd_acc    = req_ready && req_valid && !req_write;
    assign wr_acc    = req_ready && req_valid && req_write;
    assign arr_addr  = req_ready ? req_row : row_q;
    assign fixed_w   = raw_q ^ stuck_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE:    enc_in = req_wdata;
            ST_RESTORE: enc_in = fixed_w;
            default:    enc_in = arr_rdata;
        endcase
    end

    prot_hamming_enc #(.DW(DW), .P(P)) u_enc (
        .d(enc_in), .chk(enc_chk), .dpar(dpar)
    );

    prot_row_array #(.DW(DW), .NROWS(NROWS)) u_arr (
        .clk(clk), .rst_n(rst_n), .addr(arr_addr), .we(arr_we),
        .wdata(arr_wdata), .wpar(^arr_wdata), .rdata(arr_rdata), .rpar(arr_rpar),
        .flt_en(flt_en), .flt_row(flt_row), .flt_bit(flt_bit), .flt_val(flt_val)
    );

    prot_entry_table #(.NROWS(NROWS), .NENT(NENT), .NBLK(NBLK), .P(P)) u_tbl (
        .clk(clk), .rst_n(rst_n), .glob(pool_global), .lk_row(arr_addr),
        .hit(hit), .hit_idx(hit_idx), .hit_chk(hit_chk),
        .free_ok(free_ok), .free_idx(free_idx),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_row(arr_addr), .wr_chk(enc_chk)
    );

    // Decode: row parity doubles as the extended overall-parity term.
    assign par_err    = dpar ^ arr_rpar;
    assign syn        = enc_chk ^ hit_chk;
    assign sec_single = hit && par_err;
    assign sec_double = hit && !par_err && (syn != '0);
    assign no_room    = !hit && par_err && !free_ok;
    assign need_loc   = (!hit && par_err && free_ok) || sec_double;

    for (genvar gi = 0; gi < DW; gi++) begin : g_flip
        localparam logic [P-1:0] POS_W = P'(data_pos(gi));
        assign flip[gi] = (syn == POS_W);
    end

    always_comb begin
        arr_we    = 1'b0;
        arr_wdata = req_wdata;
        unique case (state_q)
            ST_IDLE:    arr_we = wr_acc;
            ST_INVERT:  begin arr_we = 1'b1; arr_wdata = ~raw_q;  end
            ST_RESTORE: begin arr_we = 1'b1; arr_wdata = fixed_w; end
            default:    arr_we = 1'b0;
        endcase
    end

    assign tbl_we  = (wr_acc && hit) || (state_q == ST_RESTORE && !dbl_q);
    assign tbl_idx = req_ready ? hit_idx : free_idx;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (rd_acc) state_d = ST_EVAL;
            ST_EVAL:    state_d = need_loc ? ST_INVERT : ST_IDLE;
            ST_INVERT:  state_d = ST_COMPARE;
            ST_COMPARE: state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
            scr_req   <= 1'b0;
            scr_blk   <= '0;
            unrep     <= '0;
            row_q     <= '0;
            raw_q     <= '0;
            stuck_q   <= '0;
            dbl_q     <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            scr_req   <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (rd_acc) row_q <= req_row;
                ST_EVAL: begin
                    raw_q <= arr_rdata;
                    dbl_q <= sec_double;
                    if (!need_loc) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= arr_rdata ^ (sec_single ? flip : '0);
                        rsp_err   <= no_room;
                        if (no_room) unrep[row_q] <= 1'b1;
                    end
                end
                ST_INVERT:  stuck_q <= '0;
                ST_COMPARE: stuck_q <= ~(arr_rdata ^ raw_q);
                ST_RESTORE: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= fixed_w;
                    rsp_err   <= 1'b0;
                    if (dbl_q) begin
                        scr_req <= 1'b1;
                        scr_blk <= row_q[ROW_W-1 -: BLK_W];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/prot_adapt_ctrl_chk.sv
module prot_adapt_ctrl_chk #(
    parameter int NROWS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             scr_req,
    input logic [NROWS-1:0] unrep
);

    // R8: responses only appear once the controller is idle again
    a_r8_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R5: scramble request is a single-cycle pulse
    a_r5_scr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        scr_req |=> !scr_req);

    // R5: scramble request accompanies a good response
    a_r5_scr_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        scr_req |-> (rsp_valid && !rsp_err));

    // R7: unrepairable flags never clear
    a_r7_unrep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unrep & $past(unrep)) == $past(unrep));

    // R7: an error response implies some row is flagged
    a_r7_err_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (unrep != '0));

endmodule

bind prot_adapt_ctrl prot_adapt_ctrl_chk #(.NROWS(NROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .scr_req(scr_req), .unrep(unrep)
);

// File: tb/prot_adapt_ctrl_bench.sv
module prot_adapt_ctrl_bench;

    localparam int DW = 8, NROWS = 8, BLK_ROWS = 4, NENT = 4;

    logic       clk = 1'b0, rst_n = 1'b0, pool_global = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_row = '0;
    logic [7:0] req_wdata = '0;
    logic       flt_en = 1'b0, flt_val = 1'b0;
    logic [2:0] flt_row = '0, flt_bit = '0;
    logic       req_ready, rsp_valid, rsp_err, scr_req;
    logic [7:0] rsp_data, unrep;
    logic [0:0] scr_blk;

    int checks = 0, fails = 0, scr_cnt = 0;
    logic [0:0] scr_last = '0;
    logic [7:0] exp_q [$];
    logic       exp_e [$];
    string      tag_q [$];
    logic [7:0] shadow [NROWS];

    always #2.5ns clk = ~clk;

    prot_adapt_ctrl #(.DW(DW), .NROWS(NROWS), .BLK_ROWS(BLK_ROWS), .NENT(NENT)) u_prot_adapt_ctrl (
        .clk(clk), .rst_n(rst_n), .pool_global(pool_global),
        .req_valid(req_valid), .req_write(req_write), .req_row(req_row), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .scr_req(scr_req), .scr_blk(scr_blk), .unrep(unrep),
        .flt_en(flt_en), .flt_row(flt_row), .flt_bit(flt_bit), .flt_val(flt_val)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every response.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected response", 32'(rsp_data), 32'h0);
                end else begin
                    logic [7:0] ed;
                    logic       ee;
                    string      t;
                    ed = exp_q.pop_front();
                    ee = exp_e.pop_front();
                    t  = tag_q.pop_front();
                    check(rsp_data == ed, {t, " data"}, 32'(rsp_data), 32'(ed));
                    check(rsp_err == ee, {t, " err"}, 32'(rsp_err), 32'(ee));
                end
            end
            if (scr_req) begin
                scr_cnt++;
                scr_last = scr_blk;
            end
        end
    end

    task automatic issue(input logic wr, input int row, input logic [7:0] d);
        logic acc;
        req_valid = 1'b1;
        req_write = wr;
        req_row   = 3'(row);
        req_wdata = d;
        acc = req_ready;
        @(negedge clk);
        while (!acc) begin
            acc = req_ready;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic wr_row(input int row, input logic [7:0] d);
        shadow[row] = d;
        issue(1'b1, row, d);
    endtask

    task automatic rd_row(input int row, input logic [7:0] d, input logic e, input string tag);
        exp_q.push_back(d);
        exp_e.push_back(e);
        tag_q.push_back(tag);
        issue(1'b0, row, 8'h00);
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 60) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(exp_q.size() == 0, "R8 every read answered", 32'(exp_q.size()), 32'h0);
    endtask

    // Stuck value is chosen opposite to the stored bit.
    task automatic inject(input int row, input int b);
        flt_en  = 1'b1;
        flt_row = 3'(row);
        flt_bit = 3'(b);
        flt_val = ~shadow[row][b];
        @(negedge clk);
        flt_en = 1'b0;
    endtask

    task automatic do_reset(input logic glob);
        rst_n = 1'b0;
        pool_global = glob;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired actual=%0d expected=<%0d", 20000, 20000);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d2;
        // ---------------- local pool phase ----------------
        do_reset(1'b0);
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        check(rsp_valid == 1'b0 && scr_req == 1'b0, "R1 strobes low", {30'h0, rsp_valid, scr_req}, 32'h0);
        check(unrep == 8'h00, "R1 unrep clear", 32'(unrep), 32'h0);

        for (int r = 0; r < NROWS; r++) wr_row(r, 8'h3C ^ 8'(r * 37));
        check(req_ready == 1'b1, "R2 ready after writes", 32'(req_ready), 32'h1);
        for (int r = 0; r < NROWS; r++) rd_row(r, shadow[r], 1'b0, "R2 R8 clean back-to-back read");
        drain();

        inject(1, 3);
        rd_row(1, shadow[1], 1'b0, "R3 R9 locate and allocate");
        rd_row(1, shadow[1], 1'b0, "R4 syndrome correction");
        drain();
        check(scr_cnt == 0, "R4 no scramble on single fault", 32'(scr_cnt), 32'h0);

        d2 = shadow[1] ^ 8'h41;
        wr_row(1, d2);
        rd_row(1, d2, 1'b0, "R10 check bits refreshed");
        drain();

        inject(1, 6);
        rd_row(1, shadow[1], 1'b0, "R5 double fault corrected");
        drain();
        check(scr_cnt == 1, "R5 one scramble pulse", 32'(scr_cnt), 32'h1);
        check(scr_last == 1'b0, "R5 scramble block", 32'(scr_last), 32'h0);

        inject(2, 0);
        rd_row(2, shadow[2], 1'b0, "R6 second local entry of block 0");
        drain();
        inject(3, 5);
        rd_row(3, shadow[3] ^ 8'h20, 1'b1, "R6 R7 R9 local pool exhausted");
        drain();
        check(unrep == 8'h08, "R7 unrep row 3", 32'(unrep), 32'h08);
        inject(5, 2);
        rd_row(5, shadow[5], 1'b0, "R6 block 1 pool still free");
        rd_row(3, shadow[3] ^ 8'h20, 1'b1, "R7 repeat read unrepaired");
        drain();
        check(unrep == 8'h08, "R7 unrep sticky", 32'(unrep), 32'h08);

        // ---------------- global pool phase ----------------
        do_reset(1'b1);
        check(unrep == 8'h00, "R1 unrep clear after second reset", 32'(unrep), 32'h0);
        for (int r = 0; r < NROWS; r++) wr_row(r, 8'hC3 ^ 8'(r * 29));
        for (int r = 0; r < 4; r++) begin
            inject(r, r + 1);
            rd_row(r, shadow[r], 1'b0, "R6 global pool serves block 0");
            drain();
        end
        for (int r = 0; r < 4; r++) rd_row(r, shadow[r], 1'b0, "R4 global rows corrected");
        drain();
        inject(4, 7);
        rd_row(4, shadow[4] ^ 8'h80, 1'b1, "R7 global pool exhausted");
        drain();
        check(unrep == 8'h10, "R7 unrep row 4", 32'(unrep), 32'h10);
        check(scr_cnt == 1, "R5 no extra scramble", 32'(scr_cnt), 32'h1);

        summary();
        $finish;
    end

endmodule